// File: doc/BRIEF.md
# Paired Event Counter Bank with Selectable Readout Order

The block holds eight small saturating event counters, one per pulse input, that gather counts while a sweep runs. A four-phase slot sequencer divides time into equal slots. In each slot one pair of counters (counters 2p and 2p+1, pair p) is taken out of service for a short dead window. During that window its values and overflow flags are copied into two read registers that the host sees together, and then the pair is zeroed and returned to counting. Counters outside the chosen pair never stop counting.

A two-bit grouping selector sets which pair each of the four slots of a round reads. Reading every pair once per round gives eight short interleaved spectra. Reading some pairs more often gives fewer, longer ones. The host picks up the two read registers on each one-cycle valid strobe and does the memory accumulation itself.

Sequencer states and transitions: OPEN (all counters live) moves to HOLD when OPEN_CYCLES cycles are spent. HOLD (selected pair blocked) moves to MOVE when HOLD_CYCLES cycles are spent. MOVE (pair still blocked, read registers load) moves to CLEAR after one cycle. CLEAR (pair zeroed) moves back to OPEN after one cycle and advances the slot index modulo 4. A slot therefore lasts OPEN_CYCLES + HOLD_CYCLES + 2 cycles.

Top module: `pair_scan_counters`

## Requirements
- R1: While reset is held and on release, rd_valid is 0, rd_pair is 0, both read values are 0 and both overflow flags are 0.
- R2: rd_valid is high for exactly one cycle per slot. It first rises after edge OPEN_CYCLES+HOLD_CYCLES (edges counted from 0 after reset release) and then every OPEN_CYCLES+HOLD_CYCLES+2 cycles. The read registers change only on the edge that raises rd_valid.
- R3: An open counter adds one for every clock edge at which its pulse input is high.
- R4: A counter at 2^CNT_W-1 holds that value. A further pulse sets its overflow flag. The flag is copied with the value at readout and cleared with the counter.
- R5: Pulses to the selected pair during HOLD and MOVE are discarded.
- R6: A pulse to the selected pair in the CLEAR cycle is counted as 1 in the new interval.
- R7: group_sel = 0 reads pairs 0,1,2,3 in slots 0..3. Pair p places counter 2p on rd_even and counter 2p+1 on rd_odd, and rd_pair gives p.
- R8: group_sel = 1 reads pairs 0,1,0,2 in slots 0..3.
- R9: group_sel = 2 reads pairs 0,1,0,1 in slots 0..3.
- R10: group_sel = 3 reads pair 0 in every slot.
- R11: Counters outside the selected pair keep counting during HOLD, MOVE and CLEAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| group_sel | input | 2 | Grouping selector; hold steady outside reset |
| pulse_in | input | 8 | One event pulse per counter, sampled each edge |
| rd_even | output | CNT_W | Captured value of counter 2p |
| rd_odd | output | CNT_W | Captured value of counter 2p+1 |
| ovf_even | output | 1 | Captured overflow flag of counter 2p |
| ovf_odd | output | 1 | Captured overflow flag of counter 2p+1 |
| rd_pair | output | 2 | Pair index p of the current read values |
| rd_valid | output | 1 | One-cycle strobe: new read values present |

## Verification
Each pulse is counted on the edge where it is sampled. A read loads on the edge that closes MOVE, so rd_valid and the new values are visible for the one cycle after that edge. The bench counts edges from reset release, applies the slot length formula to place every edge in its phase, and keeps its own tally of all eight counters and flags. At the falling edge after each MOVE edge it compares the strobe, the pair and both value/flag pairs with that tally, and at every other falling edge it checks that the strobe is low.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    typedef enum logic [1:0] {
        PH_OPEN  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_MOVE  = 2'd2,
        PH_CLEAR = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        GRP_EIGHT = 2'd0,
        GRP_MIXED = 2'd1,
        GRP_FOUR  = 2'd2,
        GRP_TWO   = 2'd3
    } group_t;

    // Pair read in a given slot for a given grouping.
    function automatic logic [1:0] pick_pair(input group_t g, input logic [1:0] s);
        logic [1:0] r;
        unique case (g)
            GRP_EIGHT: r = s;
            GRP_MIXED: r = s[0] ? (s[1] ? 2'd2 : 2'd1) : 2'd0;
            GRP_FOUR:  r = {1'b0, s[0]};
            GRP_TWO:   r = 2'd0;
            default:   r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sat_event_counter.sv
module sat_event_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             block,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clear) begin
            cnt <= CNT_W'(pulse);
            ovf <= 1'b0;
        end else if (pulse && !block) begin
            if (cnt == CNT_MAX) ovf <= 1'b1;
            else                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import pscan_pkg::*;
#(
    parameter int OPEN_CYCLES = 396,
    parameter int HOLD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    output phase_t     phase,
    output logic [1:0] slot
);
    localparam int LONGEST = (OPEN_CYCLES > HOLD_CYCLES) ? OPEN_CYCLES : HOLD_CYCLES;
    localparam int DW      = $clog2(LONGEST) + 1;
    localparam logic [DW-1:0] OPEN_LAST = DW'(OPEN_CYCLES - 1);
    localparam logic [DW-1:0] HOLD_LAST = DW'(HOLD_CYCLES - 1);

    phase_t        state_q, state_d;
    logic [DW-1:0] dwell_q, dwell_d;
    logic [1:0]    slot_q, slot_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_OPEN;
            dwell_q <= '0;
            slot_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            dwell_q <= dwell_d;
            slot_q  <= slot_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        dwell_d = dwell_q + 1'b1;
        slot_d  = slot_q;
        unique case (state_q)
            PH_OPEN: if (dwell_q == OPEN_LAST) begin
                state_d = PH_HOLD;
                dwell_d = '0;
            end
            PH_HOLD: if (dwell_q == HOLD_LAST) begin
                state_d = PH_MOVE;
                dwell_d = '0;
            end
            PH_MOVE: begin
                state_d = PH_CLEAR;
                dwell_d = '0;
            end
            PH_CLEAR: begin
                state_d = PH_OPEN;
                dwell_d = '0;
                slot_d  = slot_q + 2'd1;
            end
            default: begin
                state_d = PH_OPEN;
                dwell_d = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        phase = state_q;
        slot  = slot_q;
    end
endmodule

// File: rtl/pair_capture.sv
module pair_capture #(
    parameter int CNT_W   = 6,
    parameter int N_PAIRS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [2*N_PAIRS-1:0][CNT_W-1:0]     cnt_vec,
    input  logic [2*N_PAIRS-1:0]                ovf_vec,
    input  logic [$clog2(N_PAIRS)-1:0]          sel,
    input  logic                                capture,
    output logic [CNT_W-1:0]                    val_even,
    output logic [CNT_W-1:0]                    val_odd,
    output logic                                flag_even,
    output logic                                flag_odd,
    output logic [$clog2(N_PAIRS)-1:0]          pair_q,
    output logic                                valid_q
);
    localparam int PW = $clog2(N_PAIRS);

    logic [PW:0] idx_even, idx_odd;
    assign idx_even = {sel, 1'b0};
    assign idx_odd  = {sel, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_even  <= '0;
            val_odd   <= '0;
            flag_even <= 1'b0;
            flag_odd  <= 1'b0;
            pair_q    <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= capture;
            if (capture) begin
                val_even  <= cnt_vec[idx_even];
                val_odd   <= cnt_vec[idx_odd];
                flag_even <= ovf_vec[idx_even];
                flag_odd  <= ovf_vec[idx_odd];
                pair_q    <= sel;
            end
        end
    end
endmodule

// File: rtl/pair_scan_counters.sv
module pair_scan_counters
    import pscan_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int OPEN_CYCLES = 396,
    parameter int HOLD_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       group_sel,
    input  logic [7:0]       pulse_in,
    output logic [CNT_W-1:0] rd_even,
    output logic [CNT_W-1:0] rd_odd,
    output logic             ovf_even,
    output logic             ovf_odd,
    output logic [1:0]       rd_pair,
    output logic             rd_valid
);
    localparam int N_PAIRS = 4;
    localparam int N_CTR   = 2 * N_PAIRS;

    phase_t     phase;
    logic [1:0] slot;
    logic [1:0] pair_sel;
    logic       pair_blocked, pair_clear, capture;

    logic [N_CTR-1:0][CNT_W-1:0] cnt_vec;
    logic [N_CTR-1:0]            ovf_vec;

    slot_sequencer #(
        .OPEN_CYCLES(OPEN_CYCLES),
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .phase(phase),
        .slot (slot)
    );

    always_comb begin
        pair_sel     = pick_pair(group_t'(group_sel), slot);
        pair_blocked = (phase == PH_HOLD) || (phase == PH_MOVE);
        pair_clear   = (phase == PH_CLEAR);
        capture      = (phase == PH_MOVE);
    end

    for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
        logic in_pair;
        assign in_pair = (pair_sel == 2'(i / 2));
        sat_event_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk  (clk),
            .rst_n(rst_n),
            .pulse(pulse_in[i]),
            .block(in_pair && pair_blocked),
            .clear(in_pair && pair_clear),
            .cnt  (cnt_vec[i]),
            .ovf  (ovf_vec[i])
        );
    end

    pair_capture #(.CNT_W(CNT_W), .N_PAIRS(N_PAIRS)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_vec  (cnt_vec),
        .ovf_vec  (ovf_vec),
        .sel      (pair_sel),
        .capture  (capture),
        .val_even (rd_even),
        .val_odd  (rd_odd),
        .flag_even(ovf_even),
        .flag_odd (ovf_odd),
        .pair_q   (rd_pair),
        .valid_q  (rd_valid)
    );
endmodule

// File: rtl/pscan_checker.sv
module pscan_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       group_sel,
    input logic [CNT_W-1:0] rd_even,
    input logic [CNT_W-1:0] rd_odd,
    input logic             ovf_even,
    input logic             ovf_odd,
    input logic [1:0]       rd_pair,
    input logic             rd_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> ($stable(rd_even) && $stable(rd_odd) && $stable(rd_pair)));

    assert_ovf_even_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ovf_even) |-> (rd_even == CNT_MAX));

    assert_ovf_odd_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ovf_odd) |-> (rd_odd == CNT_MAX));

    assert_four_pairs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && group_sel == 2'd2) |-> (rd_pair[1] == 1'b0));

    assert_single_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && group_sel == 2'd3) |-> (rd_pair == 2'd0));

    assert_mixed_no_gh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && group_sel == 2'd1) |-> (rd_pair != 2'd3));
endmodule

bind pair_scan_counters pscan_checker #(.CNT_W(CNT_W)) u_pscan_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .group_sel(group_sel),
    .rd_even  (rd_even),
    .rd_odd   (rd_odd),
    .ovf_even (ovf_even),
    .ovf_odd  (ovf_odd),
    .rd_pair  (rd_pair),
    .rd_valid (rd_valid)
);

// File: tb/sim_pair_scan_counters.sv
`timescale 1ns/1ps
module sim_pair_scan_counters;
    localparam int CW    = 6;
    localparam int OPEN  = 80;
    localparam int HOLD  = 2;
    localparam int SLOTL = OPEN + HOLD + 2;
    localparam int MAXV  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    group_sel = 2'd0;
    logic [7:0]    pulse_in = 8'd0;
    logic [CW-1:0] rd_even, rd_odd;
    logic          ovf_even, ovf_odd, rd_valid;
    logic [1:0]    rd_pair;

    always #2 clk = ~clk;

    pair_scan_counters #(.CNT_W(CW), .OPEN_CYCLES(OPEN), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .group_sel(group_sel), .pulse_in(pulse_in),
        .rd_even(rd_even), .rd_odd(rd_odd), .ovf_even(ovf_even), .ovf_odd(ovf_odd),
        .rd_pair(rd_pair), .rd_valid(rd_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int       ecnt [8];
    bit       eovf [8];
    int       eb0, eb1, epair;
    bit       eo0, eo1;
    logic [15:0] lf;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pair order per grouping, from R7..R10.
    function automatic int ref_pair(input int m, input int s);
        case (m)
            0: return s;
            1: return (s == 1) ? 1 : (s == 3) ? 2 : 0;
            2: return s % 2;
            default: return 0;
        endcase
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R7";
            1: return "R8";
            2: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [7:0] gen(input int kind, input int k, input int ph,
                                       input int sl, input logic [15:0] l);
        logic [7:0] p;
        p = 8'd0;
        for (int i = 0; i < 8; i++) begin
            case (kind)
                0: p[i] = ((k % (i + 1)) == 0);
                1: p[i] = l[i] & ((i == 0) ? 1'b1 : l[i + 8]);
                default: p[i] = (i == 0 || i == 2) && sl == 0 && ph >= OPEN;
            endcase
        end
        return p;
    endfunction

    task automatic run(input int m, input int kind, input int nslots);
        bit    prev_move;
        string dtag;
        dtag = (kind == 2) ? "R5 R6 R11 R3" : "R3 R4";
        @(negedge clk);
        rst_n = 1'b0;
        group_sel = 2'(m);
        pulse_in = 8'd0;
        for (int i = 0; i < 8; i++) begin ecnt[i] = 0; eovf[i] = 0; end
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
        chk(rd_pair == 2'd0, "R1 pair", int'(rd_pair), 0);
        chk(rd_even == '0 && rd_odd == '0, "R1 values", int'(rd_even) + int'(rd_odd), 0);
        chk(!ovf_even && !ovf_odd, "R1 flags", int'(ovf_even) + int'(ovf_odd), 0);
        rst_n = 1'b1;
        prev_move = 0;
        lf = 16'hACE1 ^ 16'(m * 77);
        for (int k = 0; k <= nslots * SLOTL; k++) begin
            int ph, sl, sel;
            logic [7:0] p;
            if (prev_move) begin
                chk(rd_valid == 1'b1, "R2 strobe", int'(rd_valid), 1);
                chk(int'(rd_pair) == epair, mode_tag(m), int'(rd_pair), epair);
                chk(int'(rd_even) == eb0, {dtag, " even"}, int'(rd_even), eb0);
                chk(int'(rd_odd) == eb1, {dtag, " odd"}, int'(rd_odd), eb1);
                chk(ovf_even == eo0, "R4 ovf_even", int'(ovf_even), int'(eo0));
                chk(ovf_odd == eo1, "R4 ovf_odd", int'(ovf_odd), int'(eo1));
            end else if (k > 0) begin
                chk(rd_valid == 1'b0, "R2 idle", int'(rd_valid), 0);
            end
            ph = k % SLOTL;
            sl = (k / SLOTL) % 4;
            sel = ref_pair(m, sl);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            p = gen(kind, k, ph, sl, lf);
            pulse_in = p;
            prev_move = (ph == OPEN + HOLD);
            if (prev_move) begin
                eb0 = ecnt[2 * sel]; eb1 = ecnt[2 * sel + 1];
                eo0 = eovf[2 * sel]; eo1 = eovf[2 * sel + 1];
                epair = sel;
            end
            for (int i = 0; i < 8; i++) begin
                bit inp;
                inp = (i / 2) == sel;
                if (inp && ph == OPEN + HOLD + 1) begin
                    ecnt[i] = int'(p[i]); eovf[i] = 0;
                end else if (inp && ph >= OPEN) begin
                    // blocked window: discarded
                end else if (p[i]) begin
                    if (ecnt[i] == MAXV) eovf[i] = 1;
                    else ecnt[i] = ecnt[i] + 1;
                end
            end
            @(negedge clk);
        end
        pulse_in = 8'd0;
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            run(m, 0, 12);
            run(m, 1, 12);
        end
        run(0, 2, 8);
        run(3, 2, 4);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule